// File: doc/BRIEF.md
# Transmit Ring Frame Writer

This block loads outgoing Ethernet frames into a circular transmit area of a packet RAM that holds 16-bit words at even byte addresses. The area spans from a lower page to an upper page. Each page is 256 bytes, and the two page numbers come in on configuration inputs. The block keeps a start pointer and an end pointer for the area. While idle it reports the free space that these pointers leave.

A single-cycle `go` pulse starts a frame. It carries the destination address, the source address, the type and the payload size. The block chooses a base address for the frame and computes where the frame will end. It then writes one word per cycle: four header words, the two addresses, the type, and payload words that it pulls one at a time from the client. A frame is never split at the top of the area. If it would reach the upper limit, it starts again from the lower page. When the last word is written, the block raises a one-cycle transmit-start strobe that carries the frame base. In the next cycle it commits the new pointers.

Top module: `tx_ring_writer`

## Requirements
- R1: While `rst` is high at a clock edge, `start_ptr` and `end_ptr` are set to `{lo_page, 8'h00}` and the block goes idle (`busy` = 0). After reset, `free_bytes` equals the area size `(hi_page - lo_page + 1) * 256`.
- R2: `free_bytes` follows the pointers. It is the full area size when the two pointers are equal. It is the area size minus (end - start) when end is above start. It is start - end when end is below start.
- R3: The frame length is the payload size plus 14. The frame end is the base plus the length rounded up to the next even value after adding one, that is `((length + 3) >> 1) << 1`, plus 8 header bytes.
- R4: The base is first taken as the current `end_ptr`. If the resulting end is greater than or equal to `{hi_page, 8'h00}`, the base becomes `{lo_page, 8'h00}` and the end is recomputed from the new base.
- R5: The first four words go to the base, base+2, base+4 and base+6. They hold, in this order: the command code 16'h0004, a zero status word, the frame end, and the length.
- R6: The next seven words hold the destination address, then the source address, then the type. Each address is split into three 16-bit words, most significant bits first (bits 47:32 come first).
- R7: Exactly `(size + 3) >> 1` payload words follow the type word. Each one is pulled by a `pld_take` cycle that takes the `pld_data` presented in that same cycle. `pld_take` is high only in cycles that write a payload word.
- R8: Every write of a frame goes out in consecutive cycles to consecutive even addresses, one word per cycle, with no gaps.
- R9: In the cycle after the last write, `xmt_go` is high for exactly one cycle and `xmt_base` equals the frame base. In the following cycle, `start_ptr` equals that base, `end_ptr` equals the frame end, and `busy` is 0.
- R10: A `go` pulse that arrives while `busy` is high is ignored. The running frame's writes and its single `xmt_go` are unchanged, and no second frame is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_page | input | 8 | Lower page of the transmit area, held stable while busy |
| hi_page | input | 8 | Upper page of the transmit area, held stable while busy |
| go | input | 1 | Starts a frame when the block is idle |
| pay_size | input | SZ_W | Payload size in bytes |
| dst_mac | input | 48 | Destination address |
| src_mac | input | 48 | Source address |
| eth_type | input | 16 | Type word |
| pld_take | output | 1 | Consumes `pld_data` in this cycle |
| pld_data | input | 16 | Next payload word |
| mem_we | output | 1 | Packet RAM write enable |
| mem_addr | output | 16 | Packet RAM byte address, always even |
| mem_wdata | output | 16 | Packet RAM write word |
| xmt_go | output | 1 | Transmit-start strobe |
| xmt_base | output | 16 | Frame base that goes with `xmt_go` |
| busy | output | 1 | A frame is in progress |
| start_ptr | output | 16 | Committed start pointer |
| end_ptr | output | 16 | Committed end pointer |
| free_bytes | output | 17 | Free space in bytes |

## Verification
The hardest case to reach is the wrap decision at its exact edge. A frame whose end lands exactly on the upper-limit address must restart at the lower page. A frame two bytes shorter must stay in place. The stimulus first sends a short frame, so that the end pointer moves away from the lower page. It then computes, from that pointer, the payload size that makes the end equal the limit, and a second size two bytes smaller, and sends each of them after a fresh reset and the same short frame. The end-below-start branch of the free-space rule cannot be reached through the ports, because every committed frame ends above its own base. The stimulus therefore exercises the equal and end-above branches, with random frames that wrap many times.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;

    localparam int AW            = 16;
    localparam int DW            = 16;
    localparam int TX_HDR_BYTES  = 8;
    localparam int ETH_HDR_BYTES = 14;
    localparam int FIXED_WORDS   = 11;

    localparam logic [DW-1:0] XMT_CMD_WORD = 16'h0004;

    typedef logic [AW-1:0] addr_t;
    typedef logic [DW-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        addr_t base;
        addr_t fin;
        word_t len;
    } place_t;

    // bytes covered by pages lo..hi inclusive
    function automatic logic [AW:0] region_bytes(input logic [7:0] lo, input logic [7:0] hi);
        return ({1'b0, hi, 8'h00} - {1'b0, lo, 8'h00}) + 17'h100;
    endfunction

    // header bytes plus the rounded frame length
    function automatic addr_t frame_span(input word_t len);
        return (((len + 16'd3) >> 1) << 1) + 16'd8;
    endfunction

    function automatic logic [AW:0] free_space(input addr_t s, input addr_t e,
                                               input logic [AW:0] region);
        if (e > s)
            return region - {1'b0, e - s};
        else if (e < s)
            return {1'b0, s - e};
        else
            return region;
    endfunction

endpackage

// File: rtl/tx_place.sv
module tx_place
    import tx_ring_pkg::*;
#(
    parameter int SZ_W = 11
) (
    input  logic [7:0]      lo_page,
    input  logic [7:0]      hi_page,
    input  addr_t           cur_end,
    input  logic [SZ_W-1:0] pay_size,
    output place_t          plc,
    output logic [SZ_W:0]   pay_words
);
    localparam logic [SZ_W:0] ROUND_ADD = 3;

    word_t         len;
    addr_t         span;
    logic [AW:0]   try_end;
    logic [AW:0]   limit;
    logic          wrap;
    addr_t         base;

    always_comb begin
        len       = word_t'(pay_size) + word_t'(ETH_HDR_BYTES);
        span      = frame_span(len);
        try_end   = {1'b0, cur_end} + {1'b0, span};
        limit     = {1'b0, hi_page, 8'h00};
        wrap      = (try_end >= limit);
        base      = wrap ? {lo_page, 8'h00} : cur_end;
        plc.base  = base;
        plc.fin   = base + span;
        plc.len   = len;
        pay_words = ({1'b0, pay_size} + ROUND_ADD) >> 1;
    end

endmodule

// File: rtl/tx_word_mux.sv
module tx_word_mux
    import tx_ring_pkg::*;
#(
    parameter int IW = 12
) (
    input  logic [IW-1:0] idx,
    input  addr_t         fin,
    input  word_t         len,
    input  logic [47:0]   dst,
    input  logic [47:0]   src,
    input  word_t         etype,
    input  word_t         pld,
    output word_t         word
);
    word_t mac_w [6];

    // address words are emitted most significant slice first
    for (genvar g = 0; g < 3; g++) begin : g_mac
        assign mac_w[g]     = dst[47-16*g -: 16];
        assign mac_w[g + 3] = src[47-16*g -: 16];
    end

    always_comb begin
        word = pld;
        if (idx < IW'(FIXED_WORDS)) begin
            case (idx[3:0])
                4'd0:    word = XMT_CMD_WORD;
                4'd1:    word = '0;
                4'd2:    word = fin;
                4'd3:    word = len;
                4'd4:    word = mac_w[0];
                4'd5:    word = mac_w[1];
                4'd6:    word = mac_w[2];
                4'd7:    word = mac_w[3];
                4'd8:    word = mac_w[4];
                4'd9:    word = mac_w[5];
                4'd10:   word = etype;
                default: word = pld;
            endcase
        end
    end

endmodule

// File: rtl/tx_ring_seq.sv
module tx_ring_seq
    import tx_ring_pkg::*;
#(
    parameter int SZ_W = 11,
    localparam int IW  = SZ_W + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    lo_page,
    input  logic          go,
    input  place_t        plc_in,
    input  logic [SZ_W:0] pay_words,
    input  logic [47:0]   dst_in,
    input  logic [47:0]   src_in,
    input  word_t         type_in,
    output seq_state_e    state,
    output logic [IW-1:0] idx,
    output place_t        cur_q,
    output logic [47:0]   dst_q,
    output logic [47:0]   src_q,
    output word_t         type_q,
    output addr_t         start_q,
    output addr_t         end_q
);
    logic [IW-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            idx     <= '0;
            last_q  <= '0;
            cur_q   <= '0;
            dst_q   <= '0;
            src_q   <= '0;
            type_q  <= '0;
            start_q <= {lo_page, 8'h00};
            end_q   <= {lo_page, 8'h00};
        end else begin
            case (state)
                ST_IDLE: begin
                    if (go) begin
                        cur_q  <= plc_in;
                        dst_q  <= dst_in;
                        src_q  <= src_in;
                        type_q <= type_in;
                        last_q <= IW'(pay_words) + IW'(FIXED_WORDS - 1);
                        idx    <= '0;
                        state  <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (idx == last_q)
                        state <= ST_FIN;
                    else
                        idx <= idx + 1'b1;
                end
                ST_FIN: begin
                    start_q <= cur_q.base;
                    end_q   <= cur_q.fin;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tx_ring_writer.sv
module tx_ring_writer
    import tx_ring_pkg::*;
#(
    parameter int SZ_W = 11
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [7:0]      lo_page,
    input  logic [7:0]      hi_page,
    input  logic            go,
    input  logic [SZ_W-1:0] pay_size,
    input  logic [47:0]     dst_mac,
    input  logic [47:0]     src_mac,
    input  logic [15:0]     eth_type,
    output logic            pld_take,
    input  logic [15:0]     pld_data,
    output logic            mem_we,
    output logic [15:0]     mem_addr,
    output logic [15:0]     mem_wdata,
    output logic            xmt_go,
    output logic [15:0]     xmt_base,
    output logic            busy,
    output logic [15:0]     start_ptr,
    output logic [15:0]     end_ptr,
    output logic [16:0]     free_bytes
);
    localparam int IW = SZ_W + 1;

    place_t        plc;
    logic [SZ_W:0] pay_words;
    seq_state_e    state;
    logic [IW-1:0] idx;
    place_t        cur_q;
    logic [47:0]   dst_q;
    logic [47:0]   src_q;
    word_t         type_q;
    addr_t         start_q;
    addr_t         end_q;

    tx_place #(.SZ_W(SZ_W)) u_place (
        .lo_page   (lo_page),
        .hi_page   (hi_page),
        .cur_end   (end_q),
        .pay_size  (pay_size),
        .plc       (plc),
        .pay_words (pay_words)
    );

    tx_ring_seq #(.SZ_W(SZ_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .lo_page   (lo_page),
        .go        (go),
        .plc_in    (plc),
        .pay_words (pay_words),
        .dst_in    (dst_mac),
        .src_in    (src_mac),
        .type_in   (eth_type),
        .state     (state),
        .idx       (idx),
        .cur_q     (cur_q),
        .dst_q     (dst_q),
        .src_q     (src_q),
        .type_q    (type_q),
        .start_q   (start_q),
        .end_q     (end_q)
    );

    tx_word_mux #(.IW(IW)) u_mux (
        .idx   (idx),
        .fin   (cur_q.fin),
        .len   (cur_q.len),
        .dst   (dst_q),
        .src   (src_q),
        .etype (type_q),
        .pld   (pld_data),
        .word  (mem_wdata)
    );

    always_comb begin
        mem_we     = (state == ST_WRITE);
        pld_take   = mem_we && (idx >= IW'(FIXED_WORDS));
        mem_addr   = cur_q.base + AW'({idx, 1'b0});
        xmt_go     = (state == ST_FIN);
        xmt_base   = cur_q.base;
        busy       = (state != ST_IDLE);
        start_ptr  = start_q;
        end_ptr    = end_q;
        free_bytes = free_space(start_q, end_q, region_bytes(lo_page, hi_page));
    end

endmodule

// File: rtl/tx_ring_writer_chk.sv
module tx_ring_writer_chk
    import tx_ring_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [7:0]  lo_page,
    input logic [7:0]  hi_page,
    input logic        go,
    input logic        busy,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic [15:0] mem_wdata,
    input logic        pld_take,
    input logic        xmt_go,
    input logic [15:0] xmt_base,
    input logic [15:0] start_ptr,
    input logic [15:0] end_ptr,
    input logic [16:0] free_bytes
);
    // R2
    free_bound_chk: assert property (@(posedge clk) disable iff (rst)
        free_bytes <= region_bytes(lo_page, hi_page));

    // R5
    first_word_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !$past(mem_we)) |-> (mem_wdata == XMT_CMD_WORD));

    // R7
    take_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        pld_take |-> (mem_we && busy));

    // R8
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 16'd2));

    // R9
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        xmt_go |=> (!xmt_go && !busy && start_ptr == $past(xmt_base)));

    // R9
    end_above_start_chk: assert property (@(posedge clk) disable iff (rst)
        xmt_go |=> (end_ptr > start_ptr));

    // R10
    go_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (go && mem_we) |=> busy);

endmodule

bind tx_ring_writer tx_ring_writer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .lo_page    (lo_page),
    .hi_page    (hi_page),
    .go         (go),
    .busy       (busy),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .pld_take   (pld_take),
    .xmt_go     (xmt_go),
    .xmt_base   (xmt_base),
    .start_ptr  (start_ptr),
    .end_ptr    (end_ptr),
    .free_bytes (free_bytes)
);

// File: tb/tx_ring_writer_tb.sv
`timescale 1ns/1ps
module tx_ring_writer_tb;
    localparam int SZ_W = 11;
    localparam logic [7:0] LO = 8'h10;
    localparam logic [7:0] HI = 8'h13;
    localparam int REGION = (HI - LO + 1) * 256;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            go = 1'b0;
    logic [SZ_W-1:0] pay_size = '0;
    logic [47:0]     dst_mac = '0;
    logic [47:0]     src_mac = '0;
    logic [15:0]     eth_type = '0;
    logic            pld_take;
    logic [15:0]     pld_data;
    logic            mem_we;
    logic [15:0]     mem_addr;
    logic [15:0]     mem_wdata;
    logic            xmt_go;
    logic [15:0]     xmt_base;
    logic            busy;
    logic [15:0]     start_ptr;
    logic [15:0]     end_ptr;
    logic [16:0]     free_bytes;

    logic [15:0] pseed = '0;
    int          pidx = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    int          m_start;
    int          m_end;

    always #2.5 clk = ~clk;

    tx_ring_writer #(.SZ_W(SZ_W)) u_dut (
        .clk(clk), .rst(rst), .lo_page(LO), .hi_page(HI), .go(go),
        .pay_size(pay_size), .dst_mac(dst_mac), .src_mac(src_mac),
        .eth_type(eth_type), .pld_take(pld_take), .pld_data(pld_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .xmt_go(xmt_go), .xmt_base(xmt_base), .busy(busy),
        .start_ptr(start_ptr), .end_ptr(end_ptr), .free_bytes(free_bytes)
    );

    function automatic logic [15:0] pay_word(input logic [15:0] s, input int i);
        return (s * 16'd7) ^ (16'(i) * 16'h0111) ^ 16'h5A00;
    endfunction

    assign pld_data = pay_word(pseed, pidx);

    always @(posedge clk) begin
        if (rst || (go && !busy)) pidx <= 0;
        else if (pld_take) pidx <= pidx + 1;
    end

    function automatic int model_free(input int s, input int e);
        if (e > s) return REGION - (e - s);
        else if (e < s) return s - e;
        else return REGION;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        go  = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        m_start = {LO, 8'h00};
        m_end   = {LO, 8'h00};
        check("R1 start_ptr", int'(start_ptr), m_start);
        check("R1 end_ptr", int'(end_ptr), m_end);
        check("R1 busy", int'(busy), 0);
        check("R1 free_bytes", int'(free_bytes), REGION);
    endtask

    task automatic send(input logic [47:0] d, input logic [47:0] s,
                        input logic [15:0] t, input int size, input bit poke);
        int len, span, base, fin, pw, n;
        logic [15:0] exp;
        len  = size + 14;
        span = (((len + 3) >> 1) << 1) + 8;
        base = m_end;
        fin  = base + span;
        if (fin >= {HI, 8'h00}) begin
            base = {LO, 8'h00};
            fin  = base + span;
        end
        pw = (size + 3) >> 1;
        n  = 11 + pw;
        check("R2 free_bytes", int'(free_bytes), model_free(m_start, m_end));
        pay_size = SZ_W'(size);
        dst_mac  = d;
        src_mac  = s;
        eth_type = t;
        pseed    = d[15:0] ^ 16'(size);
        go       = 1'b1;
        @(negedge clk);
        go = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            if (i == 0)       exp = 16'h0004;
            else if (i == 1)  exp = 16'h0000;
            else if (i == 2)  exp = 16'(fin);
            else if (i == 3)  exp = 16'(len);
            else if (i < 7)   exp = 16'(d >> (16 * (6 - i)));
            else if (i < 10)  exp = 16'(s >> (16 * (9 - i)));
            else if (i == 10) exp = t;
            else              exp = pay_word(pseed, i - 11);
            check("R8 mem_we", int'(mem_we), 1);
            check(i < 4 ? "R3 R4 R5 address" : "R8 address", int'(mem_addr), base + 2 * i);
            check(i < 4 ? "R3 R5 header word" : (i < 11 ? "R6 id word" : "R7 payload word"),
                  int'(mem_wdata), int'(exp));
            check("R7 pld_take", int'(pld_take), (i >= 11) ? 1 : 0);
            if (poke && i == 2) begin
                pay_size = SZ_W'(size + 40);
                go = 1'b1;
            end else if (poke && i == 3) begin
                go = 1'b0;
            end
        end
        @(negedge clk);
        check("R9 xmt_go high", int'(xmt_go), 1);
        check("R9 xmt_base", int'(xmt_base), base);
        check("R7 writes stop", int'(mem_we), 0);
        @(negedge clk);
        check(poke ? "R10 single strobe" : "R9 single strobe", int'(xmt_go), 0);
        check("R9 start_ptr", int'(start_ptr), base);
        check("R9 end_ptr", int'(end_ptr), fin);
        check(poke ? "R10 idle after frame" : "R9 busy", int'(busy), 0);
        m_start = base;
        m_end   = fin;
        check("R2 free after frame", int'(free_bytes), model_free(m_start, m_end));
        @(negedge clk);
        check(poke ? "R10 no extra frame" : "R9 idle", int'(busy), 0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        do_reset();
        // R3 odd, zero and typical sizes
        send(48'h0102_0304_0506, 48'hA1A2_A3A4_A5A6, 16'h0800, 1, 1'b0);
        send(48'h1112_1314_1516, 48'hB1B2_B3B4_B5B6, 16'h0806, 0, 1'b0);
        send(48'hFFFF_FFFF_FFFF, 48'h0000_1111_2222, 16'h86DD, 46, 1'b0);
        // R4 end lands exactly on the upper limit: must wrap
        do_reset();
        send(48'h2222_3333_4444, 48'h5555_6666_7777, 16'h0800, 10, 1'b0);
        send(48'h2468_ACE0_1357, 48'h9BDF_0246_8ACE, 16'h0800,
             int'({HI, 8'h00}) - m_end - 24, 1'b0);
        // R4 two bytes short of the limit: stays in place
        do_reset();
        send(48'h2222_3333_4444, 48'h5555_6666_7777, 16'h0800, 10, 1'b0);
        send(48'h1357_9BDF_2468, 48'hACE0_1111_2222, 16'h0800,
             int'({HI, 8'h00}) - m_end - 26, 1'b0);
        // R10 go pulse during a frame
        send(48'hDEAD_BEEF_0001, 48'hCAFE_F00D_0002, 16'h88B5, 20, 1'b1);
        // random frames, many wraps
        for (int k = 0; k < 40; k++) begin
            send({$urandom, $urandom} >> 16, {$urandom, $urandom} >> 16,
                 16'($urandom), int'($urandom % 300), ($urandom % 8) == 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule